// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the raster timing for one video output. It has a free-running horizontal and vertical pixel counter and a small set of configuration words, and from these it derives horizontal sync, vertical sync, data-enable and a pixel-valid flag. Inside a programmable rectangle (the window) it forwards pixel data from an input port and reports the pixel's position relative to the window's corner. In active video outside that rectangle it emits a fixed background colour. All timing positions count from the first cycle of the sync pulse, so one counter origin serves sync, active video and window placement.

Software writes configuration words through a simple register port, and the writes land in a shadow set. A write to the commit address arms a transfer. The armed shadow set is copied into the working set only at the boundary where both counters return to zero, so a frame is always drawn with one consistent configuration. After reset the block runs a built-in safe timing with video blanked until software commits its own values.

Top module: `disp_timing_gen`

## Requirements
- R1: Reset clears all outputs to 0 and `cfg_rdata` to 0, and loads the default timing: 32-cycle lines, 4-cycle hsync, active columns 8 to 23, 16-line frames, 2-line vsync, active rows 4 to 11, all polarities active-high and video blanked. Nothing is shown until the first commit takes effect.
- R2: The horizontal count runs from 0 to period−1 and then wraps to 0. Word 2 holds the line period in bits 28:16 and the sync end in bits 12:0. Hsync is active while count < sync end. Control word 1 bit 4 set means hsync is active-high, and clear means active-low. All outputs are registered, so they appear one cycle after the counter state they describe.
- R3: The vertical count advances by one each time the horizontal count wraps, and wraps at period−1. Word 3 uses the same layout as word 2. Vsync is active while vertical count < sync end. Control bit 5 selects vsync polarity in the same way as bit 4 does for hsync.
- R4: Active video is the set of positions where start ≤ count < end on both axes. Words 4 and 5 hold the start in bits 28:16 and the end in bits 12:0, for horizontal and vertical respectively. `de` carries the active flag, and control bit 6 set makes it active-high.
- R5: Writes to words 1 to 8 change only the shadow set. A write of any data to address 0 arms a commit. The working set takes the shadow values at the first cycle in which both counters are 0 after the commit. Until then, all outputs follow the previous working set.
- R6: If a committed active end is greater than or equal to its period, the working active end becomes period−1. This applies to each axis separately.
- R7: Word 7 holds the window Y start in bits 28:16 and X start in bits 12:0. Word 8 holds height−1 in bits 27:16 and width−1 in bits 11:0. For an active position inside the window, `pix_valid` is 1, `pix_out` equals the value `pix_in` had in the same cycle as the counters, and `win_x`/`win_y` give the offset from the window start. Otherwise `win_x` and `win_y` are 0.
- R8: Word 6 holds the background red in bits 25:20, green in bits 15:10 and blue in bits 5:0. `pix_out` is {red, green, blue}. It carries this colour for active positions outside the window and is 0 outside active video.
- R9: Control bit 18 (blank) holds `de` at its inactive level, holds `pix_valid` at 0 and holds `pix_out` at 0, while the sync outputs keep running.
- R10: Control bit 19 (black) forces `pix_out` to 0, while `de` and `pix_valid` behave as they would without it.
- R11: `cfg_rdata` returns, one cycle after `cfg_addr` is presented, the shadow word at that address (1 to 8). It returns 0 for any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data of the shadow word |
| pix_in | input | 18 | Source pixel {r,g,b}, 6 bits each |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_valid | output | 1 | Pixel is inside the window and shown |
| win_x | output | 13 | Column offset inside the window |
| win_y | output | 13 | Row offset inside the window |
| pix_out | output | 18 | Output pixel {r,g,b} |

## Verification
A behavioural model predicts every output on every cycle. It is driven through the default timing and through a committed timing with active-high polarities and a window wholly inside active video, which separates window pass-through from background fill. A second timing flips every polarity and places a window that covers the full active width but crosses the bottom of active video, which shows whether the active and window limits are applied independently. Further configurations set an active end beyond the period (clamp), blank and black. Registers are rewritten mid-frame with and without commit, which shows whether a change lands early or tears a frame. Random pixel data each cycle exposes any latency mismatch in the pass-through path.

// File: rtl/disp_tg_pkg.sv
package disp_tg_pkg;
  localparam int CW   = 13;        // coordinate width
  localparam int SW   = 12;        // window size field width
  localparam int CCW  = 6;         // colour component width
  localparam int PW   = 3 * CCW;   // pixel width
  localparam int AW   = 4;
  localparam int DW   = 32;
  localparam int NREG = 9;

  localparam int RA_COMMIT = 0;
  localparam int RA_CTRL   = 1;
  localparam int RA_HTIM   = 2;
  localparam int RA_VTIM   = 3;
  localparam int RA_HACT   = 4;
  localparam int RA_VACT   = 5;
  localparam int RA_BG     = 6;
  localparam int RA_WPOS   = 7;
  localparam int RA_WSIZE  = 8;

  localparam int B_HPOL  = 4;
  localparam int B_VPOL  = 5;
  localparam int B_DEPOL = 6;
  localparam int B_BLANK = 18;
  localparam int B_BLACK = 19;

  typedef logic [NREG-1:0][DW-1:0] regset_t;

  typedef struct packed {
    logic [CW-1:0] htotal, hs_end, hst, hend;
    logic [CW-1:0] vtotal, vs_end, vst, vend;
    logic          hs_pol, vs_pol, de_pol, blank, black;
    logic [PW-1:0] bg;
    logic [CW-1:0] wx, wy;
    logic [SW-1:0] ww, wh;
  } tcfg_t;

  function automatic logic [CW-1:0] clamp_end(input logic [CW-1:0] tot,
                                              input logic [CW-1:0] e);
    return (tot <= e) ? tot - CW'(1) : e;
  endfunction

  function automatic tcfg_t decode_cfg(input regset_t w);
    tcfg_t c;
    c.hs_pol = w[RA_CTRL][B_HPOL];
    c.vs_pol = w[RA_CTRL][B_VPOL];
    c.de_pol = w[RA_CTRL][B_DEPOL];
    c.blank  = w[RA_CTRL][B_BLANK];
    c.black  = w[RA_CTRL][B_BLACK];
    c.htotal = w[RA_HTIM][28:16];
    c.hs_end = w[RA_HTIM][CW-1:0];
    c.vtotal = w[RA_VTIM][28:16];
    c.vs_end = w[RA_VTIM][CW-1:0];
    c.hst    = w[RA_HACT][28:16];
    c.hend   = clamp_end(c.htotal, w[RA_HACT][CW-1:0]);
    c.vst    = w[RA_VACT][28:16];
    c.vend   = clamp_end(c.vtotal, w[RA_VACT][CW-1:0]);
    c.bg     = {w[RA_BG][25:20], w[RA_BG][15:10], w[RA_BG][5:0]};
    c.wy     = w[RA_WPOS][28:16];
    c.wx     = w[RA_WPOS][CW-1:0];
    c.wh     = w[RA_WSIZE][27:16];
    c.ww     = w[RA_WSIZE][SW-1:0];
    return c;
  endfunction
endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
  import disp_tg_pkg::*;
#(
  parameter regset_t DEF_W = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          frame_end,
  output logic [DW-1:0] rdata,
  output tcfg_t         work
);
  regset_t shadow;
  logic    pending;
  logic    commit_we, load;

  assign commit_we = we && (addr == AW'(RA_COMMIT));
  assign load      = frame_end && pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow  <= DEF_W;
      pending <= 1'b0;
      work    <= decode_cfg(DEF_W);
      rdata   <= '0;
    end else begin
      rdata <= '0;
      for (int i = 1; i < NREG; i++) begin
        if (addr == AW'(i)) rdata <= shadow[i];
        if (we && addr == AW'(i)) shadow[i] <= wdata;
      end
      if (load) work <= decode_cfg(shadow);
      if (commit_we) pending <= 1'b1;
      else if (load) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/dtg_counters.sv
module dtg_counters
  import disp_tg_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] htotal,
  input  logic [CW-1:0] vtotal,
  output logic [CW-1:0] hcnt,
  output logic [CW-1:0] vcnt,
  output logic          frame_end
);
  logic hwrap, vwrap;

  assign hwrap     = hcnt >= htotal - CW'(1);
  assign vwrap     = vcnt >= vtotal - CW'(1);
  assign frame_end = hwrap && vwrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (hwrap) begin
      hcnt <= '0;
      vcnt <= vwrap ? '0 : vcnt + CW'(1);
    end else begin
      hcnt <= hcnt + CW'(1);
    end
  end
endmodule

// File: rtl/dtg_pixel.sv
module dtg_pixel
  import disp_tg_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  tcfg_t         cfg,
  input  logic [CW-1:0] hcnt,
  input  logic [CW-1:0] vcnt,
  input  logic [PW-1:0] pix_in,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          pix_valid,
  output logic [CW-1:0] win_x,
  output logic [CW-1:0] win_y,
  output logic [PW-1:0] pix_out
);
  logic          hs_on, vs_on, act, in_x, in_y, inwin, shown, valid;
  logic [CW:0]   wx_last, wy_last;
  logic [PW-1:0] data;

  assign wx_last = {1'b0, cfg.wx} + {2'b00, cfg.ww};
  assign wy_last = {1'b0, cfg.wy} + {2'b00, cfg.wh};

  always_comb begin
    hs_on = hcnt < cfg.hs_end;
    vs_on = vcnt < cfg.vs_end;
    act   = (hcnt >= cfg.hst) && (hcnt < cfg.hend) &&
            (vcnt >= cfg.vst) && (vcnt < cfg.vend);
    in_x  = (hcnt >= cfg.wx) && ({1'b0, hcnt} <= wx_last);
    in_y  = (vcnt >= cfg.wy) && ({1'b0, vcnt} <= wy_last);
    inwin = act && in_x && in_y;
    shown = act && !cfg.blank;
    valid = inwin && !cfg.blank;
    if (!shown || cfg.black) data = '0;
    else if (inwin)          data = pix_in;
    else                     data = cfg.bg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync     <= 1'b0;
      vsync     <= 1'b0;
      de        <= 1'b0;
      pix_valid <= 1'b0;
      win_x     <= '0;
      win_y     <= '0;
      pix_out   <= '0;
    end else begin
      hsync     <= cfg.hs_pol ? hs_on : !hs_on;
      vsync     <= cfg.vs_pol ? vs_on : !vs_on;
      de        <= cfg.de_pol ? shown : !shown;
      pix_valid <= valid;
      win_x     <= valid ? hcnt - cfg.wx : '0;
      win_y     <= valid ? vcnt - cfg.wy : '0;
      pix_out   <= data;
    end
  end
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import disp_tg_pkg::*;
#(
  parameter logic [CW-1:0] DEF_HTOTAL   = 13'd32,
  parameter logic [CW-1:0] DEF_HSYNC    = 13'd4,
  parameter logic [CW-1:0] DEF_HACT_ST  = 13'd8,
  parameter logic [CW-1:0] DEF_HACT_END = 13'd24,
  parameter logic [CW-1:0] DEF_VTOTAL   = 13'd16,
  parameter logic [CW-1:0] DEF_VSYNC    = 13'd2,
  parameter logic [CW-1:0] DEF_VACT_ST  = 13'd4,
  parameter logic [CW-1:0] DEF_VACT_END = 13'd12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic [17:0]   pix_in,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          pix_valid,
  output logic [12:0]   win_x,
  output logic [12:0]   win_y,
  output logic [17:0]   pix_out
);
  localparam logic [DW-1:0] DEF_CTRL =
    DW'((1 << B_HPOL) | (1 << B_VPOL) | (1 << B_DEPOL) | (1 << B_BLANK));
  localparam regset_t DEF_W = {
    32'h0, 32'h0, 32'h0,
    {3'b0, DEF_VACT_ST, 3'b0, DEF_VACT_END},
    {3'b0, DEF_HACT_ST, 3'b0, DEF_HACT_END},
    {3'b0, DEF_VTOTAL,  3'b0, DEF_VSYNC},
    {3'b0, DEF_HTOTAL,  3'b0, DEF_HSYNC},
    DEF_CTRL,
    32'h0
  };

  tcfg_t         work;
  logic [CW-1:0] hcnt, vcnt;
  logic          frame_end;

  dtg_regs #(.DEF_W(DEF_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .frame_end(frame_end), .rdata(cfg_rdata), .work(work)
  );

  dtg_counters u_cnt (
    .clk(clk), .rst(rst), .htotal(work.htotal), .vtotal(work.vtotal),
    .hcnt(hcnt), .vcnt(vcnt), .frame_end(frame_end)
  );

  dtg_pixel u_pix (
    .clk(clk), .rst(rst), .cfg(work), .hcnt(hcnt), .vcnt(vcnt),
    .pix_in(pix_in), .hsync(hsync), .vsync(vsync), .de(de),
    .pix_valid(pix_valid), .win_x(win_x), .win_y(win_y), .pix_out(pix_out)
  );
endmodule

// File: rtl/dtg_chk.sv
module dtg_chk
  import disp_tg_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic [CW-1:0] hcnt,
  input logic [CW-1:0] vcnt,
  input tcfg_t         work,
  input logic          de,
  input logic          pix_valid,
  input logic [CW-1:0] win_x,
  input logic [CW-1:0] win_y,
  input logic [PW-1:0] pix_out
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!de && !pix_valid && pix_out == '0));

  p_hstep_r2: assert property (@(posedge clk) disable iff (rst)
    (hcnt != '0) |-> (hcnt == $past(hcnt) + CW'(1)));

  p_vhold_r3: assert property (@(posedge clk) disable iff (rst)
    (hcnt != '0) |-> (vcnt == $past(vcnt)));

  p_load_at_origin_r5: assert property (@(posedge clk) disable iff (rst)
    (work != $past(work)) |-> (hcnt == '0 && vcnt == '0));

  p_end_clamped_r6: assert property (@(posedge clk) disable iff (rst)
    (work.hend < work.htotal) && (work.vend < work.vtotal));

  p_winpos_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |-> (win_x == '0 && win_y == '0));
endmodule

bind disp_timing_gen dtg_chk u_chk (
  .clk(clk), .rst(rst), .hcnt(hcnt), .vcnt(vcnt), .work(work),
  .de(de), .pix_valid(pix_valid), .win_x(win_x), .win_y(win_y),
  .pix_out(pix_out)
);

// File: tb/tb_disp_timing_gen.sv
module tb_disp_timing_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [17:0] pix_in = '0;
  logic        hsync, vsync, de, pix_valid;
  logic [12:0] win_x, win_y;
  logic [17:0] pix_out;

  int nchk = 0, nerr = 0;
  string ph = "R1 defaults";
  bit armed = 0;
  bit done = 0;
  int blank_pv = 0, blank_hs_edges = 0, black_pv = 0, black_pix = 0;
  logic prev_hs = 0;

  always #4 clk = ~clk;

  disp_timing_gen dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pix_in(pix_in),
    .hsync(hsync), .vsync(vsync), .de(de), .pix_valid(pix_valid),
    .win_x(win_x), .win_y(win_y), .pix_out(pix_out)
  );

  // reference model state
  logic [31:0] ms [9];
  bit m_pend;
  int hc, vc;
  int w_ht, w_hs, w_hst, w_hend, w_vt, w_vs, w_vst, w_vend, w_wx, w_wy, w_ww, w_wh;
  bit w_hp, w_vp, w_dp, w_bl, w_bk;
  logic [17:0] w_bg;
  logic e_hs, e_vs, e_de, e_pv;
  int e_wx, e_wy;
  logic [17:0] e_pix;
  logic [31:0] e_rd;

  function automatic logic [31:0] pack2(int hi, int lo);
    return {3'b0, 13'(hi), 3'b0, 13'(lo)};
  endfunction

  function automatic logic [31:0] ctl(bit hp, bit vp, bit dp, bit bl, bit bk);
    return (32'(hp) << 4) | (32'(vp) << 5) | (32'(dp) << 6) |
           (32'(bl) << 18) | (32'(bk) << 19);
  endfunction

  task automatic model_load();
    w_hp = ms[1][4]; w_vp = ms[1][5]; w_dp = ms[1][6];
    w_bl = ms[1][18]; w_bk = ms[1][19];
    w_ht = int'(ms[2][28:16]); w_hs = int'(ms[2][12:0]);
    w_vt = int'(ms[3][28:16]); w_vs = int'(ms[3][12:0]);
    w_hst = int'(ms[4][28:16]); w_hend = int'(ms[4][12:0]);
    w_vst = int'(ms[5][28:16]); w_vend = int'(ms[5][12:0]);
    if (w_hend >= w_ht) w_hend = w_ht - 1;  // R6
    if (w_vend >= w_vt) w_vend = w_vt - 1;
    w_bg = {ms[6][25:20], ms[6][15:10], ms[6][5:0]};
    w_wy = int'(ms[7][28:16]); w_wx = int'(ms[7][12:0]);
    w_wh = int'(ms[8][27:16]); w_ww = int'(ms[8][11:0]);
  endtask

  always @(posedge clk) begin
    if (rst) begin
      ms[0] = 0; ms[1] = ctl(1, 1, 1, 1, 0);
      ms[2] = pack2(32, 4); ms[3] = pack2(16, 2);
      ms[4] = pack2(8, 24); ms[5] = pack2(4, 12);
      ms[6] = 0; ms[7] = 0; ms[8] = 0;
      model_load();
      m_pend = 0; hc = 0; vc = 0;
      e_hs = 0; e_vs = 0; e_de = 0; e_pv = 0; e_wx = 0; e_wy = 0;
      e_pix = 0; e_rd = 0;
      armed = 1;
    end else begin
      bit act, inw, shown, hw, vw;
      act = hc >= w_hst && hc < w_hend && vc >= w_vst && vc < w_vend;
      inw = act && hc >= w_wx && hc <= w_wx + w_ww && vc >= w_wy && vc <= w_wy + w_wh;
      shown = act && !w_bl;
      e_hs = w_hp ? (hc < w_hs) : !(hc < w_hs);
      e_vs = w_vp ? (vc < w_vs) : !(vc < w_vs);
      e_de = w_dp ? shown : !shown;
      e_pv = inw && !w_bl;
      e_wx = e_pv ? hc - w_wx : 0;
      e_wy = e_pv ? vc - w_wy : 0;
      e_pix = (!shown || w_bk) ? 18'h0 : (inw ? pix_in : w_bg);
      e_rd = (cfg_addr >= 1 && cfg_addr <= 8) ? ms[cfg_addr] : 32'h0;
      hw = (hc == w_ht - 1);
      vw = (vc == w_vt - 1);
      if (hw) begin hc = 0; vc = vw ? 0 : vc + 1; end
      else hc = hc + 1;
      if (hw && vw && m_pend) begin model_load(); m_pend = 0; end
      if (cfg_we) begin
        if (cfg_addr == 0) m_pend = 1;
        else if (cfg_addr <= 8) ms[cfg_addr] = cfg_wdata;
      end
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s [%s]: actual %0h expected %0h", req, what, ph, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (armed && !done) begin
      chk(hsync === e_hs, "R2", "hsync", int'(hsync), int'(e_hs));
      chk(vsync === e_vs, "R3", "vsync", int'(vsync), int'(e_vs));
      chk(de === e_de, "R4", "de", int'(de), int'(e_de));
      chk(pix_valid === e_pv, "R7", "pix_valid", int'(pix_valid), int'(e_pv));
      chk(win_x === 13'(e_wx) && win_y === 13'(e_wy), "R7", "win_xy",
          int'({win_y, win_x}), int'({13'(e_wy), 13'(e_wx)}));
      chk(pix_out === e_pix, e_pv ? "R7" : "R8", "pix_out", int'(pix_out), int'(e_pix));
      chk(cfg_rdata === e_rd, "R11", "cfg_rdata", int'(cfg_rdata), int'(e_rd));
      if (ph == "R9 blank") begin
        if (pix_valid) blank_pv++;
        if (hsync != prev_hs) blank_hs_edges++;
      end
      if (ph == "R10 black") begin
        if (pix_valid) black_pv++;
        if (pix_out != 0) black_pix++;
      end
      prev_hs = hsync;
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cfg_we = 0;
      pix_in = 18'($urandom);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = d;
    pix_in = 18'($urandom);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    step(3);
    rst = 0;
    step(1);
    // R1: blanked default right after reset
    chk(de == 0 && pix_valid == 0 && pix_out == 0, "R1", "reset outputs",
        int'({de, pix_valid, pix_out}), 0);
    step(600);

    ph = "R5 shadow only";
    wr(1, ctl(1, 1, 1, 0, 0));
    wr(2, pack2(20, 3));
    wr(3, pack2(12, 2));
    wr(4, pack2(6, 18));
    wr(5, pack2(3, 11));
    wr(6, {6'h0, 6'h2A, 4'h0, 6'h15, 4'h0, 6'h3F});
    wr(7, pack2(4, 8));
    wr(8, {4'h0, 12'd3, 4'h0, 12'd5});
    @(negedge clk); cfg_we = 0; cfg_addr = 2;
    @(negedge clk);
    chk(cfg_rdata == pack2(20, 3), "R11", "readback word 2",
        int'(cfg_rdata), int'(pack2(20, 3)));
    step(600);

    ph = "R7 R8 window";
    wr(0, 0);
    step(1000);

    ph = "R2 R3 R4 polarity";
    wr(1, ctl(0, 0, 0, 0, 0));
    wr(7, pack2(10, 6));
    wr(8, {4'h0, 12'd5, 4'h0, 12'd11});
    wr(0, 0);
    step(800);

    ph = "R6 clamp";
    wr(1, ctl(1, 1, 1, 0, 0));
    wr(2, pack2(16, 2));
    wr(3, pack2(10, 1));
    wr(4, pack2(4, 20));
    wr(5, pack2(2, 10));
    wr(7, pack2(0, 0));
    wr(8, {4'h0, 12'd4, 4'h0, 12'd7});
    wr(0, 0);
    step(700);

    wr(1, ctl(1, 1, 1, 1, 0));
    wr(0, 0);
    step(200);
    ph = "R9 blank";
    step(300);
    chk(blank_pv == 0, "R9", "pix_valid during blank", blank_pv, 0);
    chk(blank_hs_edges > 0, "R9", "hsync edges during blank", blank_hs_edges, 1);

    ph = "R5 switch";
    wr(1, ctl(1, 1, 1, 0, 1));
    wr(0, 0);
    step(200);
    ph = "R10 black";
    step(300);
    chk(black_pv > 0, "R10", "pix_valid during black", black_pv, 1);
    chk(black_pix == 0, "R10", "nonzero pixels during black", black_pix, 0);

    finish_run();
  end
endmodule